// File: doc/BRIEF.md
# Event-to-Task Channel Fabric

This block links peripherals to each other without processor involvement. Peripherals raise single-cycle event pulses on an indexed event-input vector and accept single-cycle task strobes on an indexed task-output vector. The fabric has 32 channels. Each channel watches one event input. When that event pulses while the channel is enabled, the channel pulses two task outputs: a primary task and a fork task.

Software sets up the fabric through a simple synchronous register port. The write takes effect at the clock edge, and read data follows the address combinationally. Through this port software writes the per-channel selectors, the channel-enable mask and six channel-group membership masks. The enable mask can be written whole, or it can be changed through separate set and clear registers. Each group also has a pair of hardware strobes, enable and disable, that switch every member channel on or off together.

Channels 0 to 19 are fully programmable. On channels 20 to 31 the event and primary-task connections are fixed, but the fork selector can still be programmed.

Top module: `evtx_fabric`

## Requirements
- R1: After reset, the enable mask reads 0 and every group mask reads 0. Every programmable event, primary and fork selector reads 31 (all ones), and no task output is high.
- R2: An event input sampled high at a clock edge, on an enabled channel whose event selector holds that input's index, makes the task output named by the primary selector high for exactly one cycle, starting at that same edge. With no event input high, no task output rises.
- R3: The same event on the same channel also pulses the task named by that channel's fork selector, in the same cycle as the primary task.
- R4: A disabled channel produces no task pulse. An event selector value of 16 to 31 never matches an event, and a task selector value of 16 to 31 drives no task.
- R5: When several enabled channels hit the same task in one cycle, the result is a single strobe on that task output.
- R6: Address 0x00 reads the 32-bit enable mask (bit n is channel n), and a write to it replaces the whole mask.
- R7: A write to address 0x01 sets every enable bit written as 1. A write to address 0x02 clears every enable bit written as 1. Bits written as 0 are unchanged. Both addresses read as 0.
- R8: Group g's membership mask is at address 0x08+g, for g from 0 to 5. It is read/write. A pulse on group-enable input g sets the enabled bits of its members, and a pulse on group-disable input g clears them.
- R9: When a set action (a set write or a group enable) and a clear action (a clear write or a group disable) reach the same enable bit in the same cycle, the bit ends cleared.
- R10: Selectors are at address 0x20+c (event), 0x40+c (primary task) and 0x60+c (fork task) for channel c. For a fixed channel c = 20+k, the event selector reads k mod 16 and the primary selector reads 15 - (k mod 16). Writes to these two selectors are ignored.
- R11: Fork selectors are writable on all 32 channels, including the fixed ones, and a fixed channel fires its programmed fork task together with its fixed primary task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| evt_i | input | 16 | Event pulses from peripherals |
| grp_en_i | input | 6 | Group enable strobes |
| grp_dis_i | input | 6 | Group disable strobes |
| tsk_o | output | 16 | Task strobes to peripherals |

## Verification
The bench uses the default parameters: 32 channels with the first 20 programmable, six groups, and 16 event and 16 task lines. With these values the selectors are 5 bits wide, so the out-of-range values 16 to 31 can be written and the "not connected" behaviour can be tested. The boundary at channel 20 lies inside the register map, so writes to the fixed selectors, and forks on fixed channels, can be tested from the register port. With six groups, different groups can be driven with enable and disable in the same cycle to test that clearing wins.

// File: rtl/evtx_pkg.sv
// Package: shared constants, decoded register kinds and the fixed-channel
// wiring rule for the event-to-task fabric.
// Assumes a 32-bit data path and an 8-bit word address.
package evtx_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned CH_IDX_W = 5;

    localparam logic [ADDR_W-1:0] A_CHEN = 8'h00;
    localparam logic [ADDR_W-1:0] A_SET  = 8'h01;
    localparam logic [ADDR_W-1:0] A_CLR  = 8'h02;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHEN,
        RG_SET,
        RG_CLR,
        RG_GRP,
        RG_ESEL,
        RG_PSEL,
        RG_FSEL
    } reg_kind_e;

    // Event index that fixed channel k listens to.
    function automatic int fixed_evt(input int k, input int n_evt);
        return k % n_evt;
    endfunction

    // Primary task index that fixed channel k drives.
    function automatic int fixed_tsk(input int k, input int n_tsk);
        return n_tsk - 1 - (k % n_tsk);
    endfunction

endpackage

// File: rtl/evtx_decode.sv
// Module: evtx_decode
// Turns a word address into a register kind and an index.
// Assumes NUM_CH <= 32 and NUM_GRP <= 8. Out-of-map addresses give RG_NONE.
module evtx_decode
    import evtx_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output reg_kind_e           kind_o,
    output logic [CH_IDX_W-1:0] idx_o
);

    // Classify the address into one register kind.
    always_comb begin
        kind_o = RG_NONE;
        if (addr_i == A_CHEN)
            kind_o = RG_CHEN;
        else if (addr_i == A_SET)
            kind_o = RG_SET;
        else if (addr_i == A_CLR)
            kind_o = RG_CLR;
        else if (addr_i[7:3] == 5'd1 && int'(addr_i[2:0]) < NUM_GRP)
            kind_o = RG_GRP;
        else if (int'(addr_i[4:0]) < NUM_CH) begin
            case (addr_i[7:5])
                3'd1:    kind_o = RG_ESEL;
                3'd2:    kind_o = RG_PSEL;
                3'd3:    kind_o = RG_FSEL;
                default: kind_o = RG_NONE;
            endcase
        end
    end

    assign idx_o = addr_i[CH_IDX_W-1:0];

endmodule

// File: rtl/evtx_cfg.sv
// Module: evtx_cfg
// Holds the per-channel selectors and the group membership masks.
// Channels at or above NUM_PROG have constant event and primary selectors.
// Their fork selectors are still writable. Assumes kind/idx come from evtx_decode.
module evtx_cfg
    import evtx_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int NUM_PROG = 20,
    parameter int NUM_GRP  = 6,
    parameter int NUM_EVT  = 16,
    parameter int NUM_TSK  = 16,
    localparam int ES_W    = $clog2(NUM_EVT) + 1,
    localparam int TS_W    = $clog2(NUM_TSK) + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  reg_kind_e                          kind_i,
    input  logic [CH_IDX_W-1:0]                idx_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    output logic [NUM_CH-1:0][ES_W-1:0]        esel_o,
    output logic [NUM_CH-1:0][TS_W-1:0]        psel_o,
    output logic [NUM_CH-1:0][TS_W-1:0]        fsel_o,
    output logic [NUM_GRP-1:0][NUM_CH-1:0]     gmask_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_hit;
        logic [TS_W-1:0] fsel_q;

        assign ch_hit = wr_en_i && (idx_i == CH_IDX_W'(c));

        // Fork selector: writable on every channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fsel_q <= '1;
            else if (ch_hit && kind_i == RG_FSEL)
                fsel_q <= wdata_i[TS_W-1:0];
        end
        assign fsel_o[c] = fsel_q;

        if (c < NUM_PROG) begin : g_prog
            logic [ES_W-1:0] esel_q;
            logic [TS_W-1:0] psel_q;

            // Programmable event and primary selectors.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    esel_q <= '1;
                    psel_q <= '1;
                end else if (ch_hit) begin
                    if (kind_i == RG_ESEL)
                        esel_q <= wdata_i[ES_W-1:0];
                    if (kind_i == RG_PSEL)
                        psel_q <= wdata_i[TS_W-1:0];
                end
            end
            assign esel_o[c] = esel_q;
            assign psel_o[c] = psel_q;
        end else begin : g_fixed
            assign esel_o[c] = ES_W'(fixed_evt(c - NUM_PROG, NUM_EVT));
            assign psel_o[c] = TS_W'(fixed_tsk(c - NUM_PROG, NUM_TSK));
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [NUM_CH-1:0] gmask_q;

        // Group membership mask storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gmask_q <= '0;
            else if (wr_en_i && kind_i == RG_GRP && idx_i[2:0] == 3'(g))
                gmask_q <= wdata_i[NUM_CH-1:0];
        end
        assign gmask_o[g] = gmask_q;

        AST_GRP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && kind_i == RG_GRP && idx_i[2:0] == 3'(g))
            |=> gmask_o[g] == $past(wdata_i[NUM_CH-1:0])); // R8
    end

endmodule

// File: rtl/evtx_chen.sv
// Module: evtx_chen
// Keeps the channel-enable mask. A whole-mask write, a set write, a clear
// write and the group strobes are combined every cycle. Clear actions win
// over set actions on the same bit. Assumes NUM_CH <= DATA_W.
module evtx_chen
    import evtx_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  reg_kind_e                      kind_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [NUM_GRP-1:0]             grp_en_i,
    input  logic [NUM_GRP-1:0]             grp_dis_i,
    input  logic [NUM_GRP-1:0][NUM_CH-1:0] gmask_i,
    output logic [NUM_CH-1:0]              chen_o
);

    logic [NUM_CH-1:0] chen_q, chen_d, set_m, clr_m, base_m, wbits;

    assign wbits = wdata_i[NUM_CH-1:0];

    // Gather set and clear requests, then apply clear last.
    always_comb begin
        set_m  = (wr_en_i && kind_i == RG_SET) ? wbits : '0;
        clr_m  = (wr_en_i && kind_i == RG_CLR) ? wbits : '0;
        base_m = (wr_en_i && kind_i == RG_CHEN) ? wbits : chen_q;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_en_i[g])
                set_m = set_m | gmask_i[g];
            if (grp_dis_i[g])
                clr_m = clr_m | gmask_i[g];
        end
        chen_d = (base_m | set_m) & ~clr_m;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chen_q <= '0;
        else
            chen_q <= chen_d;
    end

    assign chen_o = chen_q;

    AST_RESET_ALL_OFF: assert property (@(posedge clk)
        !rst_n |=> chen_q == '0); // R1
    AST_CLR_BITS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kind_i == RG_CLR) |=> (chen_q & $past(wbits)) == '0); // R7
    AST_SET_BITS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && kind_i == RG_SET && grp_dis_i == '0)
        |=> (chen_q & $past(wbits)) == $past(wbits)); // R7

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        AST_GRP_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            grp_dis_i[g] |=> (chen_q & $past(gmask_i[g])) == '0); // R9
    end

endmodule

// File: rtl/evtx_route.sv
// Module: evtx_route
// Matches event inputs against each enabled channel's event selector. The
// primary and fork task strobes of every hit are ORed, and the result is
// registered, so a strobe appears one cycle after its event.
// Selector values at or above the line count match nothing.
module evtx_route #(
    parameter int NUM_CH  = 32,
    parameter int NUM_EVT = 16,
    parameter int NUM_TSK = 16,
    localparam int ES_W   = $clog2(NUM_EVT) + 1,
    localparam int TS_W   = $clog2(NUM_TSK) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_EVT-1:0]          evt_i,
    input  logic [NUM_CH-1:0]           chen_i,
    input  logic [NUM_CH-1:0][ES_W-1:0] esel_i,
    input  logic [NUM_CH-1:0][TS_W-1:0] psel_i,
    input  logic [NUM_CH-1:0][TS_W-1:0] fsel_i,
    output logic [NUM_TSK-1:0]          tsk_o
);

    logic [NUM_CH-1:0]  hit;
    logic [NUM_TSK-1:0] tsk_d, tsk_q;

    // Per-channel event match, qualified by enable.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            hit[c] = 1'b0;
            for (int e = 0; e < NUM_EVT; e++) begin
                if (esel_i[c] == ES_W'(e) && evt_i[e])
                    hit[c] = 1'b1;
            end
            hit[c] = hit[c] & chen_i[c];
        end
    end

    // OR primary and fork targets of all hitting channels.
    always_comb begin
        tsk_d = '0;
        for (int t = 0; t < NUM_TSK; t++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (hit[c] && (psel_i[c] == TS_W'(t) || fsel_i[c] == TS_W'(t)))
                    tsk_d[t] = 1'b1;
            end
        end
    end

    // Task strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tsk_q <= '0;
        else
            tsk_q <= tsk_d;
    end

    assign tsk_o = tsk_q;

    AST_NO_EVT_NO_TSK: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> tsk_o == '0); // R2
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (chen_i == '0) |=> tsk_o == '0); // R4

endmodule

// File: rtl/evtx_fabric.sv
// Module: evtx_fabric (top)
// Event-to-task channel fabric: register port, enable mask, selectors and
// routing. Read data follows the address combinationally.
// Assumes a single clock domain and single-cycle event pulses.
module evtx_fabric
    import evtx_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int NUM_PROG = 20,
    parameter int NUM_GRP  = 6,
    parameter int NUM_EVT  = 16,
    parameter int NUM_TSK  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [7:0]          addr_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic [NUM_GRP-1:0]  grp_en_i,
    input  logic [NUM_GRP-1:0]  grp_dis_i,
    output logic [NUM_TSK-1:0]  tsk_o
);

    localparam int ES_W = $clog2(NUM_EVT) + 1;
    localparam int TS_W = $clog2(NUM_TSK) + 1;

    reg_kind_e                      kind;
    logic [CH_IDX_W-1:0]            idx;
    logic [NUM_CH-1:0][ES_W-1:0]    esel;
    logic [NUM_CH-1:0][TS_W-1:0]    psel, fsel;
    logic [NUM_GRP-1:0][NUM_CH-1:0] gmask;
    logic [NUM_CH-1:0]              chen;

    evtx_decode #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_dec (
        .addr_i (addr_i),
        .kind_o (kind),
        .idx_o  (idx)
    );

    evtx_cfg #(
        .NUM_CH(NUM_CH), .NUM_PROG(NUM_PROG), .NUM_GRP(NUM_GRP),
        .NUM_EVT(NUM_EVT), .NUM_TSK(NUM_TSK)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .kind_i  (kind),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .esel_o  (esel),
        .psel_o  (psel),
        .fsel_o  (fsel),
        .gmask_o (gmask)
    );

    evtx_chen #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_chen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .kind_i    (kind),
        .wdata_i   (wdata_i),
        .grp_en_i  (grp_en_i),
        .grp_dis_i (grp_dis_i),
        .gmask_i   (gmask),
        .chen_o    (chen)
    );

    evtx_route #(.NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .NUM_TSK(NUM_TSK)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .chen_i (chen),
        .esel_i (esel),
        .psel_i (psel),
        .fsel_i (fsel),
        .tsk_o  (tsk_o)
    );

    // Read-back multiplexer; set/clear and unmapped addresses read zero.
    always_comb begin
        rdata_o = '0;
        case (kind)
            RG_CHEN: rdata_o = DATA_W'(chen);
            RG_GRP: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (idx[2:0] == 3'(g)) rdata_o = DATA_W'(gmask[g]);
            end
            RG_ESEL: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (idx == CH_IDX_W'(c)) rdata_o = DATA_W'(esel[c]);
            end
            RG_PSEL: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (idx == CH_IDX_W'(c)) rdata_o = DATA_W'(psel[c]);
            end
            RG_FSEL: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (idx == CH_IDX_W'(c)) rdata_o = DATA_W'(fsel[c]);
            end
            default: rdata_o = '0;
        endcase
    end

    AST_FIXED_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(esel[NUM_CH-1])); // R10

endmodule

// File: tb/sim_evtx_fabric.sv
`timescale 1ns/1ps
module sim_evtx_fabric;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] evt = '0;
    logic [5:0]  gen = '0;
    logic [5:0]  gdis = '0;
    logic [15:0] tsk;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    evtx_fabric u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
        .grp_en_i(gen), .grp_dis_i(gdis), .tsk_o(tsk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic grp(input logic [5:0] en, input logic [5:0] dis);
        @(negedge clk);
        gen = en; gdis = dis;
        @(negedge clk);
        gen = '0; gdis = '0;
    endtask

    // Driver: one event pulse, then the strobe and its trailing quiet cycle.
    task automatic fire(input logic [15:0] e, input logic [15:0] exp, input string tag);
        @(negedge clk);
        evt = e;
        exp_q.push_back(exp);  tag_q.push_back(tag);
        exp_q.push_back('0);   tag_q.push_back({tag, " one-cycle"});
        @(negedge clk);
        evt = '0;
        @(negedge clk);
    endtask

    // Monitor: compare the task outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0)
                chk(tag_q.pop_front(), 32'(tsk), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 enable mask");
        rd(8'h08, 32'h0, "R1 group mask 0");
        rd(8'h20, 32'd31, "R1 event sel ch0");
        rd(8'h45, 32'd31, "R1 primary sel ch5");
        rd(8'h79, 32'd31, "R1 fork sel ch25");
        chk("R1 tasks idle", 32'(tsk), 32'h0);

        // R2 primary task
        wr(8'h20, 32'd3); wr(8'h40, 32'd7);
        wr(8'h01, 32'h1);
        fire(16'h0008, 16'h0080, "R2 primary pulse");

        // R3 fork task
        wr(8'h21, 32'd4); wr(8'h41, 32'd2); wr(8'h61, 32'd9);
        wr(8'h01, 32'h2);
        fire(16'h0010, 16'h0204, "R3 primary and fork");

        // R4 disabled channel, R7 clear write
        wr(8'h02, 32'h2);
        rd(8'h00, 32'h1, "R7 clear leaves others");
        fire(16'h0010, 16'h0000, "R4 disabled channel quiet");

        // R4 unconnected selector
        wr(8'h22, 32'd20); wr(8'h42, 32'd1);
        wr(8'h01, 32'h4);
        fire(16'hFFFF, 16'h0080, "R4 unconnected event selector");

        // R5 OR of several channels
        wr(8'h23, 32'd5); wr(8'h43, 32'd7);
        wr(8'h01, 32'h8);
        fire(16'h0028, 16'h0080, "R5 merged strobe");

        // R6 whole-mask write
        wr(8'h00, 32'h8);
        rd(8'h00, 32'h8, "R6 mask replaced");
        fire(16'h0008, 16'h0000, "R6 ch0 now off");
        fire(16'h0020, 16'h0080, "R6 ch3 still on");

        // R7 zero bits unchanged, set/clear read as zero
        wr(8'h01, 32'h0);
        wr(8'h02, 32'h0);
        rd(8'h00, 32'h8, "R7 zero writes no effect");
        rd(8'h01, 32'h0, "R7 set address reads zero");

        // R8 groups
        wr(8'h08, 32'h3);
        rd(8'h08, 32'h3, "R8 group mask readback");
        grp(6'b000001, 6'b000000);
        rd(8'h00, 32'hB, "R8 group enable");
        grp(6'b000000, 6'b000001);
        rd(8'h00, 32'h8, "R8 group disable");

        // R9 clear wins
        wr(8'h09, 32'h10);
        grp(6'b000010, 6'b000010);
        rd(8'h00, 32'h8, "R9 disable beats enable");
        wr(8'h0A, 32'h20);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h01; wdata = 32'h20; gdis = 6'b000100;
        @(negedge clk);
        wr_en = 1'b0; gdis = '0;
        rd(8'h00, 32'h8, "R9 group disable beats set write");

        // R10 fixed channels
        wr(8'h34, 32'd9);
        rd(8'h34, 32'd0, "R10 fixed event ch20");
        rd(8'h54, 32'd15, "R10 fixed primary ch20");
        rd(8'h37, 32'd3, "R10 fixed event ch23");
        rd(8'h57, 32'd12, "R10 fixed primary ch23");
        wr(8'h01, 32'h0010_0000);
        fire(16'h0001, 16'h8000, "R10 fixed channel fires");

        // R11 fork on fixed channel
        wr(8'h74, 32'd6);
        rd(8'h74, 32'd6, "R11 fork sel ch20");
        fire(16'h0001, 16'h8040, "R11 fixed primary and fork");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule